// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Group Carry Terms

This block is one slice of an arithmetic/logic unit. It combines two operand words under a four-bit function code and a mode input. In arithmetic mode it produces one of sixteen sums, each with an optional carry-in. In logic mode it produces one of sixteen two-input Boolean functions, and the carry-in has no effect on the result.

Every slice also gives a ripple carry-out and a pair of group terms, group propagate and group generate. Wide words are built in one of two ways. The carry-out can feed the next slice's carry-in directly. Or an external lookahead unit can compute every slice's carry-in at once from the group terms.

The operand width is a parameter and defaults to four. A parameter selects whether the outputs pass through one register stage, which clears on a synchronous active-low reset, or come straight from the combinational logic.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode_i`=1, `f_o` is a Boolean function of A and B chosen by `sel_i` and does not depend on `carry_i`. Codes 0..15 give, in order: A, A|B, A|~B, ones, A&B, B, ~(A^B), ~A|B, A&~B, A^B, ~B, ~(A&B), zeros, ~A&B, ~A&~B, ~A.
- R2: In logic mode, code 4'b0011 drives `f_o` to all ones and code 4'b1100 drives it to all zeros, for every A, B and carry-in.
- R3: With `logic_mode_i`=0 and code 4'b1001, `f_o` is A plus B plus carry-in, modulo 2^WIDTH.
- R4: In arithmetic mode, code 4'b0110 gives A minus B minus 1 when carry-in is 0, and A minus B when carry-in is 1.
- R5: In arithmetic mode with carry-in 0, code 4'b0011 gives all ones (minus one) and code 4'b1111 gives A minus 1.
- R6: In arithmetic mode, code 4'b1100 gives A plus A plus carry-in, which is A times two when carry-in is 0.
- R7: Carry-in 1 adds exactly one to every arithmetic result. The remaining codes give A, A|B, A|~B, A+(A&~B), (A|B)+(A&~B), (A&~B)-1, A+(A&B), (A|~B)+(A&B), (A&B)-1, (A|B)+A and (A|~B)+A.
- R8: `carry_o` is the carry out of the top bit of the arithmetic sum for the selected code, including carry-in. It has the same value in logic mode.
- R9: `grp_prop_o` is 1 exactly when every bit of the code's first (OR-shaped) addend is 1. `grp_gen_o` is the carry out of the addition with carry-in 0. Neither output depends on carry-in or on the mode, and `carry_o` = `grp_gen_o` | (`grp_prop_o` & `carry_i`).
- R10: With REG_OUT=1, the outputs show the result one clock after the inputs are applied. A low `rst_n` at a clock edge clears all outputs to 0.
- R11: When slices are chained, each slice's ripple carry-in equals the carry computed by lookahead from the group terms of the slices below it, and the chained result is the full-width sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Function code |
| logic_mode_i | input | 1 | 1 = logic functions, 0 = arithmetic |
| carry_i | input | 1 | Carry into the low bit, active high |
| f_o | output | WIDTH | Result |
| carry_o | output | 1 | Ripple carry out of the top bit |
| grp_prop_o | output | 1 | Group propagate |
| grp_gen_o | output | 1 | Group generate |

## Verification
The bound assertions check a few things on every cycle. The ripple carry must equal the lookahead expression built from the group terms. The constant logic codes must give all ones or all zeros, the pass-through code must give A plus carry-in, and the register stage must show one cycle of latency. Only the bench scenarios show the full behaviour. They sweep all 32 functions over every operand and carry-in combination against a behavioural table, and run a chain of four slices whose ripple carries must match carries computed by an external lookahead.

// File: rtl/alu4_pkg.sv
// Shared constants for the ALU slice: function-code width and the codes
// whose behaviour the checker pins down explicitly.
package alu4_pkg;
    localparam int SEL_W = 4;
    typedef logic [SEL_W-1:0] alu_sel_t;
    localparam alu_sel_t SEL_PASS_A = 4'b0000;
    localparam alu_sel_t SEL_ONES   = 4'b0011;
    localparam alu_sel_t SEL_ZEROS  = 4'b1100;
endpackage

// File: rtl/alu_bit_terms.sv
// Per-bit term generator. For every bit it forms the OR-shaped addend
// (propagate) and the AND-shaped addend (generate) chosen by the code.
// Assumes the code is stable; purely combinational.
module alu_bit_terms
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_sel_t         sel,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Build both addend bits for bit i from the code.
        always_comb begin
            prop[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
            gen[i]  = (a[i] & ~b[i] & sel[2]) | (a[i] & b[i] & sel[3]);
        end
    end
endmodule

// File: rtl/alu_ripple.sv
// Ripple carry chain and sum. The internal carries are masked in logic
// mode so the result becomes prop XOR gen; the carry-out is left unmasked.
// Assumes gen implies prop per bit, which the term generator guarantees.
module alu_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             cin,
    input  logic             logic_mode,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] c;
    assign c[0] = cin;
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        // Carry into the next bit and the result bit for bit i.
        always_comb begin
            c[i+1] = gen[i] | (prop[i] & c[i]);
            sum[i] = prop[i] ^ gen[i] ^ (c[i] & ~logic_mode);
        end
    end
    assign cout = c[WIDTH];
endmodule

// File: rtl/alu_group_la.sv
// Group lookahead terms: group propagate is the AND of all bit propagates,
// group generate the carry the group would produce on its own.
// Independent of carry-in and mode.
module alu_group_la #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    output logic             grp_p,
    output logic             grp_g
);
    // Fold the generate terms from the top bit down, masked by propagates above.
    always_comb begin
        logic run_p;
        grp_g = 1'b0;
        run_p = 1'b1;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            grp_g = grp_g | (run_p & gen[i]);
            run_p = run_p & prop[i];
        end
        grp_p = &prop;
    end
endmodule

// File: rtl/alu4_slice.sv
// Top of the ALU slice. Combines the term generator, the ripple chain and the
// group lookahead. REG_OUT selects a registered (1) or direct (0) output path.
// The register uses a synchronous active-low reset.
module alu4_slice
    import alu4_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       sel_i,
    input  logic             logic_mode_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] f_o,
    output logic             carry_o,
    output logic             grp_prop_o,
    output logic             grp_gen_o
);
    localparam int OUT_W = WIDTH + 3;

    logic [WIDTH-1:0] prop, gen, f_comb;
    logic             cout_rip, grp_p, grp_g;
    logic [OUT_W-1:0] out_comb;

    alu_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .a(a_i), .b(b_i), .sel(alu_sel_t'(sel_i)), .prop(prop), .gen(gen)
    );

    alu_ripple #(.WIDTH(WIDTH)) u_ripple (
        .prop(prop), .gen(gen), .cin(carry_i), .logic_mode(logic_mode_i),
        .sum(f_comb), .cout(cout_rip)
    );

    alu_group_la #(.WIDTH(WIDTH)) u_group (
        .prop(prop), .gen(gen), .grp_p(grp_p), .grp_g(grp_g)
    );

    assign out_comb = {f_comb, cout_rip, grp_p, grp_g};

    if (REG_OUT) begin : g_reg
        logic [OUT_W-1:0] out_q;
        // Capture all outputs once per clock; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_comb;
        end
        assign {f_o, carry_o, grp_prop_o, grp_gen_o} = out_q;
    end else begin : g_direct
        assign {f_o, carry_o, grp_prop_o, grp_gen_o} = out_comb;
    end
endmodule

// File: rtl/alu4_slice_chk.sv
// Assertion checker for alu4_slice, attached by the bind below. Relates the
// ripple chain to the group terms, the constant codes and the register stage.
module alu4_slice_chk
    import alu4_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [3:0]       sel,
    input logic             logic_mode,
    input logic             cin,
    input logic [WIDTH-1:0] f_comb,
    input logic [WIDTH-1:0] f_q,
    input logic             cout_rip,
    input logic             grp_p,
    input logic             grp_g
);
    a_r9_cout_from_groups: assert property (@(posedge clk) disable iff (!rst_n)
        cout_rip == (grp_g | (grp_p & cin)));

    a_r2_logic_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_mode && sel == SEL_ONES) |-> f_comb == {WIDTH{1'b1}});

    a_r2_logic_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_mode && sel == SEL_ZEROS) |-> f_comb == '0);

    a_r7_pass_plus_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!logic_mode && sel == SEL_PASS_A) |-> f_comb == WIDTH'(a + WIDTH'(cin)));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && $past(rst_n)) |-> f_q == $past(f_comb));
endmodule

bind alu4_slice alu4_slice_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .a(a_i), .sel(sel_i), .logic_mode(logic_mode_i),
    .cin(carry_i), .f_comb(f_comb), .f_q(f_o), .cout_rip(cout_rip),
    .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/alu4_slice_tb_top.sv
module alu4_slice_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [3:0] a, b, sel, f;
    logic       mode, cin, co, pg, gg;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    alu4_slice #(.WIDTH(4), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sel_i(sel),
        .logic_mode_i(mode), .carry_i(cin), .f_o(f), .carry_o(co),
        .grp_prop_o(pg), .grp_gen_o(gg)
    );

    // Chain of four direct-output slices for the cascade scenario.
    logic [15:0] ca, cb, cf;
    logic [3:0]  csel;
    logic [4:0]  rc;
    logic [3:0]  cpg, cgg;
    for (genvar k = 0; k < 4; k++) begin : g_chain
        alu4_slice #(.WIDTH(4), .REG_OUT(1'b0)) u_s (
            .clk(clk), .rst_n(rst_n), .a_i(ca[4*k +: 4]), .b_i(cb[4*k +: 4]),
            .sel_i(csel), .logic_mode_i(1'b0), .carry_i(rc[k]),
            .f_o(cf[4*k +: 4]), .carry_o(rc[k+1]),
            .grp_prop_o(cpg[k]), .grp_gen_o(cgg[k])
        );
    end

    // Addends of the arithmetic function: result = x + y + carry-in.
    task automatic addends(input logic [3:0] s, input logic [3:0] A, input logic [3:0] B,
                           output logic [3:0] x, output logic [3:0] y);
        case (s)
            4'd0:  begin x = A;        y = 4'h0;    end
            4'd1:  begin x = A | B;    y = 4'h0;    end
            4'd2:  begin x = A | ~B;   y = 4'h0;    end
            4'd3:  begin x = 4'hF;     y = 4'h0;    end
            4'd4:  begin x = A;        y = A & ~B;  end
            4'd5:  begin x = A | B;    y = A & ~B;  end
            4'd6:  begin x = A;        y = ~B;      end
            4'd7:  begin x = 4'hF;     y = A & ~B;  end
            4'd8:  begin x = A;        y = A & B;   end
            4'd9:  begin x = A;        y = B;       end
            4'd10: begin x = A | ~B;   y = A & B;   end
            4'd11: begin x = 4'hF;     y = A & B;   end
            4'd12: begin x = A;        y = A;       end
            4'd13: begin x = A | B;    y = A;       end
            4'd14: begin x = A | ~B;   y = A;       end
            default: begin x = A;      y = 4'hF;    end
        endcase
    endtask

    function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] A,
                                             input logic [3:0] B);
        case (s)
            4'd0: return A;          4'd1: return A | B;
            4'd2: return A | ~B;     4'd3: return 4'hF;
            4'd4: return A & B;      4'd5: return B;
            4'd6: return ~(A ^ B);   4'd7: return ~A | B;
            4'd8: return A & ~B;     4'd9: return A ^ B;
            4'd10: return ~B;        4'd11: return ~(A & B);
            4'd12: return 4'h0;      4'd13: return ~A & B;
            4'd14: return ~A & ~B;   default: return ~A;
        endcase
    endfunction

    function automatic string f_tag(input logic m, input logic [3:0] s, input logic c);
        if (m) return (s == 4'd3 || s == 4'd12) ? "R2" : "R1";
        if (s == 4'd9) return "R3";
        if (s == 4'd6) return "R4";
        if ((s == 4'd3 || s == 4'd15) && !c) return "R5";
        if (s == 4'd12) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (sel=%0h mode=%0b a=%0h b=%0h cin=%0b)",
                     req, act, exp, sel, mode, a, b, cin);
        end
    endtask

    initial begin
        a = 4'h5; b = 4'hA; sel = 4'd9; mode = 1'b0; cin = 1'b1;
        ca = '0; cb = '0; csel = 4'd9; rc[0] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears every output even with live inputs.
        check("R10 reset f", int'(f), 0);
        check("R10 reset flags", int'({co, pg, gg}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep: all 32 functions, every operand and carry-in.
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                for (int c = 0; c < 2; c++)
                    for (int ia = 0; ia < 16; ia++)
                        for (int ib = 0; ib < 16; ib++) begin
                            logic [3:0] x, y;
                            int total, gsum;
                            @(negedge clk);
                            a = 4'(ia); b = 4'(ib); sel = 4'(s); mode = 1'(m); cin = 1'(c);
                            addends(sel, a, b, x, y);
                            total = int'(x) + int'(y) + c;
                            gsum  = int'(x) + int'(y);
                            // R10: result visible after exactly one clock edge.
                            @(posedge clk);
                            #1;
                            if (m == 1) check(f_tag(1'b1, sel, cin), int'(f), int'(logic_ref(sel, a, b)));
                            else        check(f_tag(1'b0, sel, cin), int'(f), total % 16);
                            check("R8 carry_o", int'(co), total / 16);
                            check("R9 grp_prop_o", int'(pg), int'((x | y) == 4'hF));
                            check("R9 grp_gen_o", int'(gg), gsum / 16);
                        end

        // R11: chained slices against external lookahead and full-width sum.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ea;
            logic [4:0]  la;
            @(negedge clk);
            ca = 16'($urandom); cb = 16'($urandom); rc[0] = 1'($urandom);
            csel = (n % 2 == 0) ? 4'd9 : 4'd6;
            #1;
            la[0] = rc[0];
            for (int k = 0; k < 4; k++) la[k+1] = cgg[k] | (cpg[k] & la[k]);
            for (int k = 1; k < 5; k++) check("R11 lookahead carry", int'(rc[k]), int'(la[k]));
            ea = (csel == 4'd9) ? ca + cb + 16'(rc[0]) : ca - cb - 16'(!rc[0]);
            check("R11 chained result", int'(cf), int'(ea));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule